// File: doc/BRIEF.md
# Mode-Selectable System Clock Divider

This block derives a processor clock, a bus clock, a free-running copy of the bus clock and a reference clock from one fast source clock. Two strap pins choose between an idle state with outputs released, a test state driven from the slow reference input, and two run states that differ only in the processor clock rate. In both run states the bus clock stays at one rate (source divided by 6, 33.3 MHz from a 200 MHz source), and each of its rising edges falls on a processor rising edge.

All outputs come from one phase counter that spans a single bus-clock period. The processor and bus waveforms are decoded from that counter, so their alignment holds by structure. In test mode the counter advances only on rising edges of the reference input, after synchronisation. Active-high enables stop the processor clock and the gated bus clock. A stopped clock is held low, and it only stops or restarts while its waveform is low, so no pulse is ever shortened. Output tristate is modelled as one drive-enable flag per output group.

Mode states, with code {freq_sel, mode_sel}:
- ST_TRISTATE (00)
- ST_RUN_SLOW (01)
- ST_TEST (10)
- ST_RUN_FAST (11)

Any change of the code is a transition straight to the state it names, and that transition restarts the phase counter.

Top module: `sysclk_divider`

## Requirements
- R1: Code 00 (ST_TRISTATE) drives cpu_oe, pci_oe and ref_oe low and holds cpu_clk, pci_clk, pci_free_clk and ref_clk low. Reset enters this state.
- R2: Code 11 (ST_RUN_FAST): cpu_clk has a period of 2 source cycles and stays high for 1 of them.
- R3: Code 01 (ST_RUN_SLOW): cpu_clk has a period of 3 source cycles and stays high for 2 of them.
- R4: Each rising edge of pci_free_clk coincides with a rising edge of cpu_clk while cpu_en is high.
- R5: Code 10 (ST_TEST) uses the reference input period T as its base. cpu_clk has period 2T and is high for T. pci_clk and pci_free_clk have period 6T and are high for 3T. ref_clk has period T.
- R6: In both run states ref_clk follows the reference input, with the same period.
- R7: pci_en low holds pci_clk low while pci_free_clk keeps running. Every pci_clk high pulse lasts the full 3 source cycles in run states.
- R8: cpu_en low holds cpu_clk low while the bus clocks keep running. Every cpu_clk high pulse keeps its full length across stop and restart.
- R9: A change of the select code restarts the counter. At the first edge after the change, cpu_clk, pci_clk and pci_free_clk all go high together.
- R10: In run states pci_clk and pci_free_clk have a period of 6 source cycles and a high time of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock (200 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_clk | input | 1 | Slow reference / test clock input |
| freq_sel | input | 1 | Frequency select, upper code bit |
| mode_sel | input | 1 | Mode select, lower code bit |
| cpu_en | input | 1 | Processor clock enable, active high |
| pci_en | input | 1 | Gated bus clock enable, active high |
| cpu_clk | output | 1 | Processor clock |
| pci_clk | output | 1 | Gated bus clock |
| pci_free_clk | output | 1 | Free-running bus clock |
| ref_clk | output | 1 | Reference clock |
| cpu_oe | output | 1 | Drive enable, processor group |
| pci_oe | output | 1 | Drive enable, bus group |
| ref_oe | output | 1 | Drive enable, reference group |

## Verification
A wrong phase count or a wrong mode decode shows up within one bus period (6 source cycles, or 6 reference periods in test mode). It appears as a wrong cpu_clk period or high time, or as a bus-clock rise with no processor rise beside it. A gate that updates at the wrong moment produces a shortened high pulse at the first restart after an enable toggles. A missed counter restart leaves the outputs low at the first edge after a select change. The bench sweeps every ordered pair of active modes to catch that case.

// File: rtl/sysclk_divider_pkg.sv
package sysclk_divider_pkg;
    // encoding is {freq_sel, mode_sel}
    typedef enum logic [1:0] {
        ST_TRISTATE = 2'b00,
        ST_RUN_SLOW = 2'b01,
        ST_TEST     = 2'b10,
        ST_RUN_FAST = 2'b11
    } clk_mode_e;
endpackage

// File: rtl/sysclk_mode_fsm.sv
module sysclk_mode_fsm
    import sysclk_divider_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      freq_sel,
    input  logic      mode_sel,
    output clk_mode_e state,
    output clk_mode_e mode_nxt,
    output logic      restart,
    output logic      cpu_oe,
    output logic      pci_oe,
    output logic      ref_oe
);
    always_comb begin
        unique case ({freq_sel, mode_sel})
            2'b00:   mode_nxt = ST_TRISTATE;
            2'b01:   mode_nxt = ST_RUN_SLOW;
            2'b10:   mode_nxt = ST_TEST;
            default: mode_nxt = ST_RUN_FAST;
        endcase
    end

    assign restart = (mode_nxt != state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_TRISTATE;
        else        state <= mode_nxt;
    end

    always_comb begin
        unique case (state)
            ST_TRISTATE: {cpu_oe, pci_oe, ref_oe} = 3'b000;
            ST_RUN_SLOW,
            ST_TEST,
            ST_RUN_FAST: {cpu_oe, pci_oe, ref_oe} = 3'b111;
            default:     {cpu_oe, pci_oe, ref_oe} = 3'b000;
        endcase
    end
endmodule

// File: rtl/sysclk_ref_sync.sv
module sysclk_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_clk,
    output logic ref_lvl,
    output logic ref_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], xtal_clk};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ref_lvl  = sync_q[SYNC_STAGES-1];
    assign ref_rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/sysclk_phase_gen.sv
module sysclk_phase_gen
    import sysclk_divider_pkg::*;
#(
    parameter int BUS_DIV  = 6,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  clk_mode_e state,
    input  clk_mode_e mode_nxt,
    input  logic      restart,
    input  logic      ref_rise,
    input  logic      cpu_en,
    input  logic      pci_en,
    output logic      cpu_clk,
    output logic      pci_clk,
    output logic      pci_free_clk
);
    localparam int PH_W    = $clog2(BUS_DIV);
    localparam int BUS_HI  = BUS_DIV / 2;
    localparam int FAST_HI = (FAST_DIV + 1) / 2;
    localparam int SLOW_HI = (SLOW_DIV + 1) / 2;

    logic [PH_W-1:0] phase_q, phase_nxt;
    logic            adv, cpu_pat, bus_pat;
    logic            cpu_gate_q, pci_gate_q, cpu_gate_nxt, pci_gate_nxt;
    logic            fresh_q;

    always_comb begin
        adv = (mode_nxt == ST_TEST) ? ref_rise : 1'b1;
        if (restart || mode_nxt == ST_TRISTATE)
            phase_nxt = '0;
        else if (adv)
            phase_nxt = (int'(phase_q) == BUS_DIV - 1) ? '0 : phase_q + 1'b1;
        else
            phase_nxt = phase_q;
        bus_pat = (int'(phase_nxt) < BUS_HI);
        unique case (mode_nxt)
            ST_RUN_SLOW: cpu_pat = (int'(phase_nxt) % SLOW_DIV) < SLOW_HI;
            ST_RUN_FAST,
            ST_TEST:     cpu_pat = (int'(phase_nxt) % FAST_DIV) < FAST_HI;
            default:     cpu_pat = 1'b0;
        endcase
        if (mode_nxt == ST_TRISTATE) bus_pat = 1'b0;
        // gates only move while the waveform they guard is low
        cpu_gate_nxt = cpu_pat ? cpu_gate_q : cpu_en;
        pci_gate_nxt = bus_pat ? pci_gate_q : pci_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q      <= '0;
            cpu_gate_q   <= 1'b0;
            pci_gate_q   <= 1'b0;
            cpu_clk      <= 1'b0;
            pci_clk      <= 1'b0;
            pci_free_clk <= 1'b0;
            fresh_q      <= 1'b0;
        end else begin
            phase_q      <= phase_nxt;
            cpu_gate_q   <= cpu_gate_nxt;
            pci_gate_q   <= pci_gate_nxt;
            cpu_clk      <= cpu_pat & cpu_gate_nxt;
            pci_clk      <= bus_pat & pci_gate_nxt;
            pci_free_clk <= bus_pat;
            fresh_q      <= restart;
        end
    end

    // R4: a bus rise away from a restart brings a processor rise with it
    assert_bus_cpu_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pci_free_clk) && cpu_gate_q && !fresh_q) |-> $rose(cpu_clk));

    // R2: fast mode with a steady open gate toggles every source cycle
    assert_fast_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN_FAST && $past(state) == ST_RUN_FAST && !fresh_q
         && cpu_gate_q && $past(cpu_gate_q)) |-> (cpu_clk != $past(cpu_clk)));

    // R3, R8: a slow-mode processor high pulse lasts at least two cycles
    assert_slow_full_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_clk) && state == ST_RUN_SLOW && !fresh_q) |=> (cpu_clk || fresh_q));

    // R7: the gated bus clock is never high while the free one is low
    assert_gated_under_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pci_clk |-> pci_free_clk);
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
    import sysclk_divider_pkg::*;
#(
    parameter int BUS_DIV     = 6,
    parameter int FAST_DIV    = 2,
    parameter int SLOW_DIV    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic xtal_clk,
    input  logic freq_sel,
    input  logic mode_sel,
    input  logic cpu_en,
    input  logic pci_en,
    output logic cpu_clk,
    output logic pci_clk,
    output logic pci_free_clk,
    output logic ref_clk,
    output logic cpu_oe,
    output logic pci_oe,
    output logic ref_oe
);
    clk_mode_e state, mode_nxt;
    logic      restart, ref_lvl, ref_rise;

    sysclk_mode_fsm u_fsm (
        .clk(clk_src), .rst_n(rst_n), .freq_sel(freq_sel), .mode_sel(mode_sel),
        .state(state), .mode_nxt(mode_nxt), .restart(restart),
        .cpu_oe(cpu_oe), .pci_oe(pci_oe), .ref_oe(ref_oe)
    );

    sysclk_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ref (
        .clk(clk_src), .rst_n(rst_n), .xtal_clk(xtal_clk),
        .ref_lvl(ref_lvl), .ref_rise(ref_rise)
    );

    sysclk_phase_gen #(.BUS_DIV(BUS_DIV), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_phase (
        .clk(clk_src), .rst_n(rst_n), .state(state), .mode_nxt(mode_nxt),
        .restart(restart), .ref_rise(ref_rise), .cpu_en(cpu_en), .pci_en(pci_en),
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_free_clk(pci_free_clk)
    );

    assign ref_clk = ref_lvl & ref_oe;

    // R1: released state keeps every clock output quiet
    assert_tristate_quiet_R1: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == ST_TRISTATE) |-> !(cpu_clk || pci_clk || pci_free_clk || ref_clk));
endmodule

// File: tb/sysclk_divider_tb.sv
module sysclk_divider_tb;
    logic clk = 1'b0, rst_n = 1'b0, xtal = 1'b0;
    logic fsel = 1'b0, msel = 1'b0, cen = 1'b1, pen = 1'b1;
    logic cpu, pci, pfree, refc, coe, poe, roe;
    int   n_chk = 0, n_fail = 0;
    int   per_min[4], per_max[4], hi_min[4], hi_max[4], rises[4], last_r[4], hcnt[4];
    bit   hv[4];
    int   misal;

    localparam int XH = 4;      // reference half period in source cycles
    localparam int XP = 2 * XH;

    always #2.5 clk = ~clk;

    initial forever begin
        repeat (XH) @(negedge clk);
        xtal = ~xtal;
    end

    sysclk_divider u_dut (
        .clk_src(clk), .rst_n(rst_n), .xtal_clk(xtal), .freq_sel(fsel), .mode_sel(msel),
        .cpu_en(cen), .pci_en(pen), .cpu_clk(cpu), .pci_clk(pci), .pci_free_clk(pfree),
        .ref_clk(refc), .cpu_oe(coe), .pci_oe(poe), .ref_oe(roe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic observe(input int n);
        logic prev[4], cur[4];
        for (int s = 0; s < 4; s++) begin
            per_min[s] = 1000000; per_max[s] = 0; hi_min[s] = 1000000; hi_max[s] = 0;
            rises[s] = 0; last_r[s] = -1; hcnt[s] = 0; hv[s] = 0; prev[s] = 1'b1;
        end
        misal = 0;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            cur[0] = cpu; cur[1] = pci; cur[2] = pfree; cur[3] = refc;
            if (t > 0 && cur[2] && !prev[2] && !(cur[0] && !prev[0])) misal++;
            for (int s = 0; s < 4; s++) begin
                if (t > 0 && cur[s] && !prev[s]) begin
                    rises[s]++;
                    if (last_r[s] >= 0) begin
                        if (t - last_r[s] < per_min[s]) per_min[s] = t - last_r[s];
                        if (t - last_r[s] > per_max[s]) per_max[s] = t - last_r[s];
                    end
                    last_r[s] = t; hv[s] = 1; hcnt[s] = 0;
                end
                if (cur[s]) hcnt[s]++;
                if (!cur[s] && prev[s] && hv[s]) begin
                    if (hcnt[s] < hi_min[s]) hi_min[s] = hcnt[s];
                    if (hcnt[s] > hi_max[s]) hi_max[s] = hcnt[s];
                end
                prev[s] = cur[s];
            end
        end
    endtask

    task automatic set_mode(input logic f, input logic m);
        @(negedge clk);
        fsel = f; msel = m;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({cpu, pci, pfree, refc, coe, poe, roe} == 7'b0, "R1 reset outputs",
              {cpu, pci, pfree, refc, coe, poe, roe}, 0);
        rst_n = 1'b1;
        observe(30);
        check(rises[0] + rises[1] + rises[2] + rises[3] == 0, "R1 tristate no edges",
              rises[0] + rises[1] + rises[2] + rises[3], 0);
        check({coe, poe, roe} == 3'b000, "R1 oe low", {coe, poe, roe}, 0);

        // fast run mode
        set_mode(1'b1, 1'b1);
        repeat (10) @(negedge clk);
        observe(60);
        check(per_min[0] == 2 && per_max[0] == 2, "R2 cpu period", per_max[0], 2);
        check(hi_min[0] == 1 && hi_max[0] == 1, "R2 cpu high", hi_max[0], 1);
        check(per_min[1] == 6 && per_max[1] == 6 && hi_max[1] == 3 && hi_min[1] == 3,
              "R10 pci fast", per_max[1], 6);
        check(per_max[2] == 6 && hi_min[2] == 3, "R10 pci_free fast", per_max[2], 6);
        check(misal == 0, "R4 fast align", misal, 0);
        check(per_min[3] == XP && per_max[3] == XP, "R6 ref fast", per_max[3], XP);
        check({coe, poe, roe} == 3'b111, "R1 oe high when running", {coe, poe, roe}, 7);

        // slow run mode with immediate restart check
        set_mode(1'b0, 1'b1);
        @(negedge clk);
        check(cpu && pci && pfree, "R9 restart to slow", {cpu, pci, pfree}, 7);
        observe(60);
        check(per_min[0] == 3 && per_max[0] == 3, "R3 cpu period", per_max[0], 3);
        check(hi_min[0] == 2 && hi_max[0] == 2, "R3 cpu high", hi_max[0], 2);
        check(per_max[1] == 6 && per_min[1] == 6 && hi_min[1] == 3, "R10 pci slow", per_max[1], 6);
        check(misal == 0, "R4 slow align", misal, 0);
        check(per_max[3] == XP && per_min[3] == XP, "R6 ref slow", per_max[3], XP);

        // processor stop, slow mode
        cen = 1'b0;
        repeat (5) @(negedge clk);
        observe(30);
        check(rises[0] == 0 && cpu == 1'b0, "R8 cpu held low", rises[0], 0);
        check(rises[2] >= 4 && per_max[2] == 6, "R8 bus runs while cpu stopped", per_max[2], 6);
        fork
            observe(90);
            begin
                repeat (17) @(negedge clk); cen = 1'b1;
                repeat (23) @(negedge clk); cen = 1'b0;
                repeat (19) @(negedge clk); cen = 1'b1;
            end
        join
        check(hi_min[0] == 2 && hi_max[0] == 2, "R8 cpu full pulses across toggles", hi_min[0], 2);

        // bus stop, fast mode
        set_mode(1'b1, 1'b1);
        pen = 1'b0;
        repeat (8) @(negedge clk);
        observe(30);
        check(rises[1] == 0 && pci == 1'b0, "R7 pci held low", rises[1], 0);
        check(rises[2] >= 4 && per_max[2] == 6, "R7 pci_free keeps running", per_max[2], 6);
        fork
            observe(90);
            begin
                repeat (13) @(negedge clk); pen = 1'b1;
                repeat (29) @(negedge clk); pen = 1'b0;
                repeat (17) @(negedge clk); pen = 1'b1;
            end
        join
        check(hi_min[1] == 3 && hi_max[1] == 3, "R7 pci full pulses across toggles", hi_min[1], 3);

        // test mode
        set_mode(1'b1, 1'b0);
        @(negedge clk);
        check(cpu && pci && pfree, "R9 restart to test", {cpu, pci, pfree}, 7);
        repeat (4) @(negedge clk);
        observe(220);
        check(per_min[0] == 2 * XP && per_max[0] == 2 * XP && hi_max[0] == XP,
              "R5 cpu in test", per_max[0], 2 * XP);
        check(per_min[1] == 6 * XP && per_max[1] == 6 * XP && hi_min[1] == 3 * XP,
              "R5 pci in test", per_max[1], 6 * XP);
        check(per_max[2] == 6 * XP && hi_max[2] == 3 * XP, "R5 pci_free in test", per_max[2], 6 * XP);
        check(per_min[3] == XP && per_max[3] == XP, "R5 ref in test", per_max[3], XP);
        check(misal == 0, "R4 test align", misal, 0);

        // sweep of every ordered pair of active modes
        for (int a = 1; a < 4; a++) begin
            for (int b = 1; b < 4; b++) begin
                if (a != b) begin
                    set_mode(a[1], a[0]);
                    repeat (7 + a + 2 * b) @(negedge clk);
                    set_mode(b[1], b[0]);
                    @(negedge clk);
                    check(cpu && pci && pfree, $sformatf("R9 restart %0d->%0d", a, b),
                          {cpu, pci, pfree}, 7);
                end
            end
        end

        // back to released state
        set_mode(1'b0, 1'b0);
        @(negedge clk);
        observe(40);
        check(rises[0] + rises[1] + rises[2] + rises[3] == 0 && {cpu, pci, pfree, refc} == 4'b0,
              "R1 tristate after run", rises[0] + rises[1] + rises[2] + rises[3], 0);
        check({coe, poe, roe} == 3'b000, "R1 oe released", {coe, poe, roe}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule